// File: doc/BRIEF.md
# Character LCD Common Scan Timer

This block generates the row-scan timing for a multiplexed character LCD driver with sixteen common outputs. Two line-mode and font-height bits select one of three duty factors: 1/8, 1/11 or 1/16. The block divides the oscillator clock into common periods and steps through the active common in a loop. At the start of every common period it gives a one-cycle strobe, so that the segment latch takes that row's data.

Alongside the one-hot common drive, it reports several values to the logic around it. For the font lookup it gives the row inside the character cell and the display line. It also marks the underline-cursor row, gives the bias choice, and gives an AC polarity flag in either of two inversion schemes. A slow blink phase for the cursor and character blinking comes out as well. An orientation input swaps the two halves of the common order and reports that the segment order must be reversed.

All pins are plain control and status signals. No data stream crosses the block's edge, so it has no valid/ready handshake and never back-pressures. Mode inputs are sampled every cycle and may change at any time.

Top module: `lcd_com_scan`

## Requirements
- R1: The duty follows the mode inputs. With `two_line`=1 the common index cycles 0..15 and `tall_font` has no effect. With `two_line`=0 it cycles 0..10 when `tall_font`=1 and 0..7 when `tall_font`=0.
- R2: Each common period lasts ROW_CLKS_LONG clocks at 1/8 and 1/11 duty and ROW_CLKS_SHORT clocks at 1/16 duty. A frame is the number of commons times that period.
- R3: `seg_latch` is high for exactly the first clock of each common period, including the first clock after reset.
- R4: `bias_fifth` is 1 at 1/16 duty and 0 at the other two duties.
- R5: With `wave_b`=0, `ac_pol` inverts at the end of every common period. With `wave_b`=1, it inverts only at the end of each frame.
- R6: At 1/16 duty, `font_row` is the common index modulo 8 and `line_sel` is 1 for common indices 8..15. At the other duties, `font_row` equals the common index and `line_sel` is 0.
- R7: `cursor_row` is 1 exactly when `font_row` is 7, the eighth row of the cell.
- R8: `com_drive` has exactly one bit set. With `orient_std`=1 it is bit `com_idx`; with `orient_std`=0 it is bit `com_idx` XOR 8, which swaps the halves. `seg_reverse` is the inverse of `orient_std`.
- R9: `blink_phase` inverts after every BLINK_FRAMES complete frames.
- R10: Reset clears the period counter and the common index. It also sets `ac_pol` and `blink_phase` to 0.
- R11: If the duty shrinks while the common index lies beyond the new last common, the index returns to 0 at the end of the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| two_line | input | 1 | Line-mode bit: 1 selects two display lines |
| tall_font | input | 1 | Font bit: 1 selects the 5x10 cell in one-line mode |
| wave_b | input | 1 | Inversion scheme: 0 inverts per common period, 1 inverts per frame |
| orient_std | input | 1 | Orientation: 1 keeps the natural common order, 0 swaps the halves |
| com_drive | output | 16 | One-hot physical common select |
| com_idx | output | 4 | Logical active common index |
| seg_latch | output | 1 | One-cycle strobe at the start of a common period |
| font_row | output | 4 | Row inside the character cell |
| line_sel | output | 1 | Display line for the current row |
| cursor_row | output | 1 | Current row is the underline-cursor row |
| bias_fifth | output | 1 | 1 selects 1/5 bias, 0 selects 1/4 |
| ac_pol | output | 1 | Drive polarity flag |
| blink_phase | output | 1 | Blink phase for cursor and character blinking |
| seg_reverse | output | 1 | Segment outputs must run in reverse order |

## Verification
The bench builds the block with ROW_CLKS_LONG=6, ROW_CLKS_SHORT=3 and BLINK_FRAMES=2. With these values a full frame takes at most 66 clocks, and two blink inversions fit inside a few hundred clocks. That makes it practical to sweep all sixteen combinations of the mode inputs. For each combination, every cycle is compared against values computed from the elapsed cycle count. One further case shrinks the duty in the middle of a frame, with the index above the new limit.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int NUM_COM = 16;
  localparam int COM_W   = $clog2(NUM_COM);

  typedef enum logic [1:0] {
    DUTY_8  = 2'd0,
    DUTY_11 = 2'd1,
    DUTY_16 = 2'd2
  } duty_e;

  function automatic logic [COM_W-1:0] last_common(duty_e d);
    case (d)
      DUTY_16: last_common = COM_W'(15);
      DUTY_11: last_common = COM_W'(10);
      default: last_common = COM_W'(7);
    endcase
  endfunction
endpackage

// File: rtl/lcd_duty_sel.sv
module lcd_duty_sel
  import lcd_scan_pkg::*;
#(
  parameter int ROW_CLKS_LONG  = 800,
  parameter int ROW_CLKS_SHORT = 400,
  parameter int CNT_W          = 10
) (
  input  logic             two_line,
  input  logic             tall_font,
  output duty_e            duty,
  output logic [COM_W-1:0] com_last,
  output logic [CNT_W-1:0] period_last,
  output logic             bias_fifth
);
  always_comb begin
    if (two_line)       duty = DUTY_16;
    else if (tall_font) duty = DUTY_11;
    else                duty = DUTY_8;
    com_last    = last_common(duty);
    period_last = (duty == DUTY_16) ? CNT_W'(ROW_CLKS_SHORT - 1)
                                    : CNT_W'(ROW_CLKS_LONG - 1);
    bias_fifth  = (duty == DUTY_16);
  end
endmodule

// File: rtl/lcd_row_timer.sv
module lcd_row_timer
  import lcd_scan_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_last,
  input  logic [COM_W-1:0] com_last,
  output logic [COM_W-1:0] com_idx,
  output logic             row_start,
  output logic             row_wrap,
  output logic             frame_wrap
);
  logic [CNT_W-1:0] cnt_q;
  logic [COM_W-1:0] com_q;

  assign row_wrap   = (cnt_q >= period_last);
  assign frame_wrap = row_wrap && (com_q >= com_last);
  assign row_start  = (cnt_q == '0);
  assign com_idx    = com_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      com_q <= '0;
    end else if (row_wrap) begin
      cnt_q <= '0;
      com_q <= (com_q >= com_last) ? '0 : com_q + COM_W'(1);
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R3: the start strobe never lasts two cycles
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    row_start |=> !row_start);
  // R2: the common index moves only into a new period
  a_r2_com_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !row_start |-> $stable(com_q));
  // R11: after a wrap the index never lands beyond the last common
  a_r11_wrap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wrap && $stable(com_last)) |=> (com_q == '0));
endmodule

// File: rtl/lcd_phase_gen.sv
module lcd_phase_gen #(
  parameter int BLINK_FRAMES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wave_b,
  input  logic row_wrap,
  input  logic frame_wrap,
  output logic ac_pol,
  output logic blink_phase
);
  localparam int FC_W = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1;

  logic [FC_W-1:0] frames_q;
  logic            pol_q;
  logic            blink_q;
  logic            pol_step;

  assign pol_step    = wave_b ? frame_wrap : row_wrap;
  assign ac_pol      = pol_q;
  assign blink_phase = blink_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q    <= 1'b0;
      blink_q  <= 1'b0;
      frames_q <= '0;
    end else begin
      if (pol_step) pol_q <= ~pol_q;
      if (frame_wrap) begin
        if (frames_q == FC_W'(BLINK_FRAMES - 1)) begin
          frames_q <= '0;
          blink_q  <= ~blink_q;
        end else begin
          frames_q <= frames_q + FC_W'(1);
        end
      end
    end
  end

  // R5: polarity moves only on a period boundary
  a_r5_pol_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(row_wrap) |-> $stable(pol_q));
  // R9: blink moves only on a frame boundary
  a_r9_blink_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_wrap) |-> $stable(blink_q));
endmodule

// File: rtl/lcd_com_map.sv
module lcd_com_map
  import lcd_scan_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COM_W-1:0]   com_idx,
  input  logic               orient_std,
  output logic [NUM_COM-1:0] com_drive
);
  localparam logic [COM_W-1:0] HALF = COM_W'(NUM_COM / 2);

  for (genvar p = 0; p < NUM_COM; p++) begin : g_pin
    localparam logic [COM_W-1:0] NAT = COM_W'(p);
    assign com_drive[p] = orient_std ? (com_idx == NAT)
                                     : (com_idx == (NAT ^ HALF));
  end

  // R8: exactly one common driven at any time
  a_r8_one_common: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(com_drive) == 1);
endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan
  import lcd_scan_pkg::*;
#(
  parameter int ROW_CLKS_LONG  = 800,
  parameter int ROW_CLKS_SHORT = 400,
  parameter int BLINK_FRAMES   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        two_line,
  input  logic        tall_font,
  input  logic        wave_b,
  input  logic        orient_std,
  output logic [15:0] com_drive,
  output logic [3:0]  com_idx,
  output logic        seg_latch,
  output logic [3:0]  font_row,
  output logic        line_sel,
  output logic        cursor_row,
  output logic        bias_fifth,
  output logic        ac_pol,
  output logic        blink_phase,
  output logic        seg_reverse
);
  localparam int MAX_CLKS = (ROW_CLKS_LONG > ROW_CLKS_SHORT) ? ROW_CLKS_LONG : ROW_CLKS_SHORT;
  localparam int CNT_W    = $clog2(MAX_CLKS);

  duty_e            duty;
  logic [COM_W-1:0] com_last;
  logic [CNT_W-1:0] period_last;
  logic             row_wrap;
  logic             frame_wrap;

  lcd_duty_sel #(
    .ROW_CLKS_LONG (ROW_CLKS_LONG),
    .ROW_CLKS_SHORT(ROW_CLKS_SHORT),
    .CNT_W         (CNT_W)
  ) u_duty (
    .two_line   (two_line),
    .tall_font  (tall_font),
    .duty       (duty),
    .com_last   (com_last),
    .period_last(period_last),
    .bias_fifth (bias_fifth)
  );

  lcd_row_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_last(period_last),
    .com_last   (com_last),
    .com_idx    (com_idx),
    .row_start  (seg_latch),
    .row_wrap   (row_wrap),
    .frame_wrap (frame_wrap)
  );

  lcd_phase_gen #(.BLINK_FRAMES(BLINK_FRAMES)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .wave_b     (wave_b),
    .row_wrap   (row_wrap),
    .frame_wrap (frame_wrap),
    .ac_pol     (ac_pol),
    .blink_phase(blink_phase)
  );

  lcd_com_map u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .com_idx   (com_idx),
    .orient_std(orient_std),
    .com_drive (com_drive)
  );

  always_comb begin
    if (duty == DUTY_16) begin
      font_row = {1'b0, com_idx[2:0]};
      line_sel = com_idx[3];
    end else begin
      font_row = com_idx;
      line_sel = 1'b0;
    end
    cursor_row  = (font_row == 4'd7);
    seg_reverse = ~orient_std;
  end

  // R6: the second display line exists only in two-line mode
  a_r6_line_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
    line_sel |-> two_line);
  // R4: fifth bias only with the short period mode
  a_r4_bias_two_line: assert property (@(posedge clk) disable iff (!rst_n)
    bias_fifth == two_line);
endmodule

// File: tb/lcd_com_scan_bench.sv
`timescale 1ns/1ps
module lcd_com_scan_bench;
  localparam int PL = 6;
  localparam int PS = 3;
  localparam int BF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic two_line = 1'b0, tall_font = 1'b0, wave_b = 1'b0, orient_std = 1'b1;
  logic [15:0] com_drive;
  logic [3:0]  com_idx, font_row;
  logic seg_latch, line_sel, cursor_row, bias_fifth, ac_pol, blink_phase, seg_reverse;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lcd_com_scan #(.ROW_CLKS_LONG(PL), .ROW_CLKS_SHORT(PS), .BLINK_FRAMES(BF)) u_lcd_com_scan (
    .clk(clk), .rst_n(rst_n), .two_line(two_line), .tall_font(tall_font),
    .wave_b(wave_b), .orient_std(orient_std), .com_drive(com_drive),
    .com_idx(com_idx), .seg_latch(seg_latch), .font_row(font_row),
    .line_sel(line_sel), .cursor_row(cursor_row), .bias_fifth(bias_fifth),
    .ac_pol(ac_pol), .blink_phase(blink_phase), .seg_reverse(seg_reverse)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sweep(input bit tl, input bit tf, input bit wb, input bit os);
    int p, d, row, line, phys;
    two_line = tl; tall_font = tf; wave_b = wb; orient_std = os;
    do_reset();
    d = tl ? 16 : (tf ? 11 : 8);
    p = tl ? PS : PL;
    // R10: state right after reset
    chk("R10 com_idx", com_idx, 0);
    chk("R10 ac_pol", ac_pol, 0);
    chk("R10 blink", blink_phase, 0);
    for (int t = 0; t <= 4 * p * d; t++) begin
      int c;
      c = (t / p) % d;
      chk("R1/R2 com_idx", com_idx, c);
      chk("R3 seg_latch", seg_latch, (t % p == 0) ? 1 : 0);
      chk("R4 bias", bias_fifth, (d == 16) ? 1 : 0);
      chk("R5 ac_pol", ac_pol, wb ? ((t / (p * d)) % 2) : ((t / p) % 2));
      row  = (d == 16) ? c % 8 : c;
      line = (d == 16 && c >= 8) ? 1 : 0;
      chk("R6 font_row", font_row, row);
      chk("R6 line_sel", line_sel, line);
      chk("R7 cursor_row", cursor_row, (row == 7) ? 1 : 0);
      phys = os ? c : (c ^ 8);
      chk("R8 com_drive", int'(com_drive), 1 << phys);
      chk("R8 seg_reverse", seg_reverse, os ? 0 : 1);
      chk("R9 blink", blink_phase, (t / (p * d * BF)) % 2);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 16; m++)
      sweep(m[0], m[1], m[2], m[3]);

    // R11: shrink the duty while the index sits at common 12
    two_line = 1'b1; tall_font = 1'b0; wave_b = 1'b0; orient_std = 1'b1;
    do_reset();
    repeat (12 * PS) @(negedge clk);
    chk("R11 pre-switch com_idx", com_idx, 12);
    two_line = 1'b0;
    for (int k = 0; k < PL; k++) begin
      chk("R11 hold com_idx", com_idx, 12);
      @(negedge clk);
    end
    chk("R11 wrapped com_idx", com_idx, 0);
    chk("R11 wrapped latch", seg_latch, 1);
    @(negedge clk);
    chk("R11 latch drops", seg_latch, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule